// File: doc/BRIEF.md
# Cascaded Segment Column Data Loader

This block collects one display line for a 160-column segment driver and turns it into a 2-bit drive-level code per column. Pixel data arrives on a parallel bus, either one full 8-bit group or one 4-bit half-group per shift strobe. Several stages share the bus and sit in a chain: each stage waits after a line pulse until its enable input is pulled low, takes 160 bits, then pulses its enable output low for one strobe period so that the next stage starts taking data.

A single direction input reverses both the column fill order and which of the two enable pins is the input and which the output. The falling edge of the line pulse copies the whole collected line into a line latch, which drives the level encoder together with an AC-phase input and an active-low blanking input. Everything runs on one system clock; the shift strobe and line pulse are synchronous qualifiers sampled on that clock. The direction input is expected to stay stable from a line pulse until the line has been loaded.

Top module: `lcd_col_loader`

## Requirements
- R1: With `wide_mode` high, each accepted strobe writes one 8-bit group from `bus_d[7:0]`; the 20th accepted strobe completes the line.
- R2: With `wide_mode` low, accepted strobes are paired: the first supplies group bits 3:0 and the second group bits 7:4, both from `bus_d[3:0]`; the 40th accepted strobe completes the line.
- R3: With `dir` low, pin 1 is the enable output (`en1_oe`=1, `en2_oe`=0) and `en2_in` is the enable input; with `dir` high the roles swap. The enable output that is not in use stays 1.
- R4: After a line pulse the stage waits; a strobe taken while the active enable input is 0 selects it, and it then stays selected until the line is complete, after which it is deselected. Strobes taken while waiting with the enable input at 1, or after completion, leave the collected data unchanged.
- R5: The active enable output is 1, except that it drops to 0 in the cycle after the strobe that completes the line and returns to 1 after the next strobe (or a line pulse).
- R6: Columns numbered 0..159: with `dir` low, group k (k=0 first) bit i goes to column 152-8k+i; with `dir` high, to column 8k+7-i.
- R7: On the clock where `line_pulse` is sampled low after being sampled high, the collected bits are copied to the line latch at once; while `line_pulse` is high, loading control and the group position restart, abandoning a partial line.
- R8: While `blank_n` is low every output code is V5 and the line latch is cleared; the collected data is kept and reappears after the next line pulse.
- R9: Column c drives `lvl_o[2c+1:2c]` with codes V0=0, V12=1, V43=2, V5=3: with `ac_phase` low a line bit of 1 gives V5 and 0 gives V43; with `ac_phase` high 1 gives V0 and 0 gives V12. After reset the line latch holds zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_en | input | 1 | Shift strobe, one bus transfer per high cycle |
| bus_d | input | 8 | Parallel pixel data |
| wide_mode | input | 1 | 1: 8-bit transfers, 0: 4-bit transfers |
| dir | input | 1 | Fill direction and enable pin role select |
| line_pulse | input | 1 | Line pulse; restarts loading, falling edge latches the line |
| ac_phase | input | 1 | AC drive phase |
| blank_n | input | 1 | Active-low display blanking |
| en1_in | input | 1 | Enable pin 1, input side |
| en2_in | input | 1 | Enable pin 2, input side |
| en1_out | output | 1 | Enable pin 1, output side |
| en2_out | output | 1 | Enable pin 2, output side |
| en1_oe | output | 1 | Enable pin 1 drive enable |
| en2_oe | output | 1 | Enable pin 2 drive enable |
| lvl_o | output | 320 | 2-bit level code per column |

## Verification
The assertions assume that `dir` and `wide_mode` do not change between a line pulse and the completion of the line, and that a shift strobe never coincides with a line pulse or its falling edge. The stimulus changes these inputs only while `line_pulse` is high or the line is idle, issues a line pulse before each load, and separates every strobe by an idle cycle, so strobes and line pulses never overlap.

// File: rtl/lcd_col_pkg.sv
package lcd_col_pkg;

  // R9 drive level codes
  typedef enum logic [1:0] {
    LV_V0  = 2'd0,
    LV_V12 = 2'd1,
    LV_V43 = 2'd2,
    LV_V5  = 2'd3
  } lvl_e;

  typedef enum logic [1:0] {
    LD_WAIT = 2'd0,
    LD_TAKE = 2'd1,
    LD_DONE = 2'd2
  } ld_state_e;

  // Level selection from AC phase, line bit and blanking
  function automatic lvl_e seg_level(input logic ac, input logic on, input logic blank_n);
    if (!blank_n) return LV_V5;
    if (ac) return on ? LV_V0 : LV_V12;
    return on ? LV_V5 : LV_V43;
  endfunction

endpackage

// File: rtl/lcd_col_assembler.sv
module lcd_col_assembler #(
  parameter int GW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          take,
  input  logic          wide,
  input  logic [GW-1:0] bus,
  output logic          grp_wr,
  output logic [GW-1:0] grp_byte
);
  localparam int HW = GW / 2;

  logic          half_q;
  logic [HW-1:0] hold_q;

  // R1 / R2: full group now, or the second half of a pair
  assign grp_wr   = take & (wide | half_q);
  assign grp_byte = wide ? bus : {bus[HW-1:0], hold_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      hold_q <= '0;
    end else if (clr) begin
      half_q <= 1'b0;
    end else if (take && !wide) begin
      half_q <= ~half_q;
      if (!half_q) hold_q <= bus[HW-1:0];
    end
  end

  // R2
  narrow_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_wr && !wide && !clr) |=> !half_q);

endmodule

// File: rtl/lcd_col_select.sv
module lcd_col_select
  import lcd_col_pkg::*;
#(
  parameter int NG = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lp,
  input  logic          shift_en,
  input  logic          ein,
  input  logic          dir,
  input  logic          grp_wr,
  output logic          take,
  output logic [NG-1:0] slot_oh,
  output logic          eo_n,
  output logic          last_wr
);
  localparam logic [NG-1:0] FIRST_LO = {1'b1, {(NG-1){1'b0}}};
  localparam logic [NG-1:0] FIRST_HI = {{(NG-1){1'b0}}, 1'b1};

  ld_state_e     st_q;
  logic [NG-1:0] ptr_q;
  logic          at_end;
  logic          eo_q;

  assign at_end  = dir ? ptr_q[NG-1] : ptr_q[0];
  assign take    = shift_en & ~lp & ((st_q == LD_TAKE) | ((st_q == LD_WAIT) & ~ein));
  assign last_wr = grp_wr & at_end;
  assign slot_oh = ptr_q;
  assign eo_n    = eo_q;

  // R6 group position pointer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  ptr_q <= FIRST_LO;
    else if (lp)                 ptr_q <= dir ? FIRST_HI : FIRST_LO;
    else if (grp_wr && !at_end)  ptr_q <= dir ? (ptr_q << 1) : (ptr_q >> 1);
  end

  // R4 selection state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            st_q <= LD_WAIT;
    else if (lp)                           st_q <= LD_WAIT;
    else if (last_wr)                      st_q <= LD_DONE;
    else if (take && st_q == LD_WAIT)      st_q <= LD_TAKE;
  end

  // R5 cascade pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  eo_q <= 1'b1;
    else if (lp)                 eo_q <= 1'b1;
    else if (last_wr)            eo_q <= 1'b0;
    else if (shift_en && !eo_q)  eo_q <= 1'b1;
  end

  // R6
  ptr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ptr_q) == 1);

  // R5
  eo_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!eo_q && shift_en) |=> eo_q);

  // R4
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LD_DONE && !lp) |=> $stable(ptr_q));

  // R4
  wait_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LD_WAIT && ein && !lp) |=> (st_q == LD_WAIT && $stable(ptr_q)));

endmodule

// File: rtl/lcd_col_latch.sv
module lcd_col_latch #(
  parameter int COLS = 160,
  parameter int GW   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 dir,
  input  logic                 grp_wr,
  input  logic [COLS/GW-1:0]   slot_oh,
  input  logic [GW-1:0]        grp_byte,
  input  logic                 lp_fall,
  input  logic                 blank_n,
  output logic [COLS-1:0]      line_q
);
  localparam int NG = COLS / GW;

  function automatic logic [GW-1:0] rev_grp(input logic [GW-1:0] v);
    logic [GW-1:0] r;
    for (int i = 0; i < GW; i++) r[i] = v[GW-1-i];
    return r;
  endfunction

  logic [COLS-1:0] data_q;
  logic [COLS-1:0] data_d;
  logic [GW-1:0]   wr_val;

  // R6 bit order within a group follows the direction
  assign wr_val = dir ? rev_grp(grp_byte) : grp_byte;

  for (genvar s = 0; s < NG; s++) begin : g_slot
    assign data_d[s*GW +: GW] = (grp_wr && slot_oh[s]) ? wr_val : data_q[s*GW +: GW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else        data_q <= data_d;
  end

  // R7 / R8 line latch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       line_q <= '0;
    else if (!blank_n) line_q <= '0;
    else if (lp_fall)  line_q <= data_q;
  end

  // R8
  blank_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_n |=> (line_q == '0));

  // R7
  line_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_fall && blank_n) |=> (line_q == $past(data_q)));

  // R8
  data_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !grp_wr |=> $stable(data_q));

endmodule

// File: rtl/lcd_col_loader.sv
module lcd_col_loader
  import lcd_col_pkg::*;
#(
  parameter int COLS = 160,
  parameter int GW   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic [GW-1:0]     bus_d,
  input  logic              wide_mode,
  input  logic              dir,
  input  logic              line_pulse,
  input  logic              ac_phase,
  input  logic              blank_n,
  input  logic              en1_in,
  input  logic              en2_in,
  output logic              en1_out,
  output logic              en2_out,
  output logic              en1_oe,
  output logic              en2_oe,
  output logic [2*COLS-1:0] lvl_o
);
  localparam int NG = COLS / GW;

  logic          lp_q;
  logic          lp_fall;
  logic          ein;
  logic          take;
  logic          grp_wr;
  logic [GW-1:0] grp_byte;
  logic [NG-1:0] slot_oh;
  logic          eo_n;
  logic          last_wr;
  logic [COLS-1:0] line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lp_q <= 1'b0;
    else        lp_q <= line_pulse;
  end
  assign lp_fall = lp_q & ~line_pulse;

  // R3 enable pin roles
  assign ein     = dir ? en1_in : en2_in;
  assign en1_out = dir ? 1'b1 : eo_n;
  assign en2_out = dir ? eo_n : 1'b1;
  assign en1_oe  = ~dir;
  assign en2_oe  = dir;

  lcd_col_select #(.NG(NG)) u_sel (
    .clk(clk), .rst_n(rst_n), .lp(line_pulse), .shift_en(shift_en),
    .ein(ein), .dir(dir), .grp_wr(grp_wr), .take(take),
    .slot_oh(slot_oh), .eo_n(eo_n), .last_wr(last_wr)
  );

  lcd_col_assembler #(.GW(GW)) u_asm (
    .clk(clk), .rst_n(rst_n), .clr(line_pulse), .take(take),
    .wide(wide_mode), .bus(bus_d), .grp_wr(grp_wr), .grp_byte(grp_byte)
  );

  lcd_col_latch #(.COLS(COLS), .GW(GW)) u_lat (
    .clk(clk), .rst_n(rst_n), .dir(dir), .grp_wr(grp_wr),
    .slot_oh(slot_oh), .grp_byte(grp_byte), .lp_fall(lp_fall),
    .blank_n(blank_n), .line_q(line_q)
  );

  // R9 per-column level code
  for (genvar c = 0; c < COLS; c++) begin : g_col
    assign lvl_o[2*c +: 2] = seg_level(ac_phase, line_q[c], blank_n);
  end

  // R5
  last_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_wr |=> !eo_n);

  // R8
  blank_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_n |-> (lvl_o == {(2*COLS){1'b1}}));

endmodule

// File: tb/tb_lcd_col_loader.sv
`timescale 1ns/1ps
module tb_lcd_col_loader;
  localparam int COLS = 160;
  localparam int GW   = 8;

  logic clk = 1'b0, rst_n = 1'b0, shift_en = 1'b0, wide = 1'b1, dir = 1'b0;
  logic lp = 1'b0, ac = 1'b0, blank_n = 1'b1, ein = 1'b1;
  logic [GW-1:0] bus = '0;
  logic en1_out, en2_out, en1_oe, en2_oe;
  logic [2*COLS-1:0] lvl;

  lcd_col_loader #(.COLS(COLS), .GW(GW)) dut (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .bus_d(bus),
    .wide_mode(wide), .dir(dir), .line_pulse(lp), .ac_phase(ac),
    .blank_n(blank_n), .en1_in(ein), .en2_in(ein), .en1_out(en1_out),
    .en2_out(en2_out), .en1_oe(en1_oe), .en2_oe(en2_oe), .lvl_o(lvl)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  string tag = "R9";

  // behavioural reference
  int m_data[COLS];
  int m_line[COLS];
  int m_st, m_k, m_half, m_hold, m_eo, m_lpq;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < COLS; c++) begin m_data[c] = 0; m_line[c] = 0; end
      m_st = 0; m_k = 0; m_half = 0; m_hold = 0; m_eo = 1; m_lpq = 0;
    end else begin
      if (!blank_n) for (int c = 0; c < COLS; c++) m_line[c] = 0;
      else if (m_lpq == 1 && !lp) for (int c = 0; c < COLS; c++) m_line[c] = m_data[c];
      m_lpq = lp;
      if (lp) begin
        m_st = 0; m_k = 0; m_half = 0; m_eo = 1;
      end else if (shift_en) begin
        int g;
        bit w;
        w = 0; g = 0;
        if (m_eo == 0) m_eo = 1;
        if (m_st == 0 && !(dir ? ein : ein)) m_st = 1;
        if (m_st == 1) begin
          if (wide) begin g = int'(bus); w = 1; end
          else if (m_half == 0) begin m_hold = int'(bus) % 16; m_half = 1; end
          else begin g = (int'(bus) % 16) * 16 + m_hold; m_half = 0; w = 1; end
          if (w) begin
            for (int i = 0; i < 8; i++) begin
              int col;
              col = dir ? (8*m_k + 7 - i) : (152 - 8*m_k + i);
              m_data[col] = (g >> i) & 1;
            end
            if (m_k == 19) begin m_st = 2; m_eo = 0; end
            m_k++;
          end
        end
      end
    end
  end

  function automatic int code_of(int b);
    if (!blank_n) return 3;
    if (ac) return b ? 0 : 1;
    return b ? 3 : 2;
  endfunction

  function automatic int pat(int seed, int n);
    return (seed * 37 + n * 29 + 11) % 256;
  endfunction

  task automatic check(string t, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  task automatic compare();
    int bad;
    bad = -1;
    for (int c = 0; c < COLS; c++)
      if (bad < 0 && int'(lvl[2*c +: 2]) !== code_of(m_line[c])) bad = c;
    n_chk++;
    if (bad >= 0) begin
      n_fail++;
      $display("FAIL %s R9 level col %0d actual=%0d expected=%0d", tag, bad,
               int'(lvl[2*bad +: 2]), code_of(m_line[bad]));
    end
    check({tag, " R5 en1_out"}, int'(en1_out), dir ? 1 : m_eo);
    check({tag, " R5 en2_out"}, int'(en2_out), dir ? m_eo : 1);
    check({tag, " R3 en1_oe"}, int'(en1_oe), dir ? 0 : 1);
  endtask

  task automatic tick();
    @(posedge clk); #1;
    if (rst_n) compare();
  endtask

  task automatic shift(int d);
    bus = d[GW-1:0]; shift_en = 1'b1; tick(); shift_en = 1'b0; tick();
  endtask

  task automatic pulse_lp();
    lp = 1'b1; tick(); lp = 1'b0; tick();
  endtask

  task automatic col_chk(string t, int c, int b);
    check(t, int'(lvl[2*c +: 2]), code_of(b));
  endtask

  initial begin
    #(5.0 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1; tick();
    check("R9 reset level V43", int'(lvl[1:0]), 2);

    // R1 / R6: 8-bit, dir low
    tag = "R1"; pulse_lp();
    ein = 1'b0;
    for (int n = 0; n < 20; n++) begin
      shift(pat(1, n));
      if (n == 0) ein = 1'b1;
      check("R1 completion on 20th strobe", int'(en1_out), n == 19 ? 0 : 1);
    end
    // R4: strobes after completion ignored
    tag = "R4"; ein = 1'b0;
    for (int n = 0; n < 3; n++) shift(8'hA5);
    ein = 1'b1;
    pulse_lp();
    col_chk("R6 first group bit0 at col 152", 152, pat(1, 0) & 1);
    col_chk("R6 first group bit7 at col 159", 159, (pat(1, 0) >> 7) & 1);
    col_chk("R6 last group bit7 at col 7", 7, (pat(1, 19) >> 7) & 1);
    col_chk("R4 late strobes left col 0", 0, pat(1, 19) & 1);

    // R2 / R3: 4-bit, dir high
    tag = "R2"; dir = 1'b1; wide = 1'b0; lp = 1'b1; tick();
    check("R3 en2_oe with dir high", int'(en2_oe), 1);
    check("R3 en1_out idle high", int'(en1_out), 1);
    lp = 1'b0; tick();
    ein = 1'b0;
    for (int n = 0; n < 40; n++) begin
      shift(pat(2, n));
      if (n == 0) ein = 1'b1;
      check("R2 completion on 40th strobe", int'(en2_out), n == 39 ? 0 : 1);
    end
    pulse_lp();
    col_chk("R2 first nibble bit0 to col 7", 7, pat(2, 0) & 1);
    col_chk("R2 second nibble bit0 to col 3", 3, pat(2, 1) & 1);
    col_chk("R6 last group top nibble bit3 at col 152", 152, (pat(2, 39) >> 3) & 1);

    // R4: unselected strobes ignored
    tag = "R4"; ein = 1'b1;
    for (int n = 0; n < 5; n++) shift(pat(3, n));
    pulse_lp();
    col_chk("R4 unselected strobes ignored col 7", 7, pat(2, 0) & 1);

    // R7: partial line abandoned by line pulse
    tag = "R7"; dir = 1'b0; wide = 1'b1; pulse_lp();
    ein = 1'b0;
    for (int n = 0; n < 5; n++) shift(8'h00);
    pulse_lp();
    for (int n = 0; n < 20; n++) shift(pat(4, n));
    ein = 1'b1;
    pulse_lp();
    col_chk("R7 restart fills col 152 from first group", 152, pat(4, 0) & 1);
    col_chk("R7 restart fills col 0", 0, pat(4, 19) & 1);

    // R9: AC phase
    tag = "R9"; ac = 1'b1; tick();
    col_chk("R9 ac high level col 152", 152, pat(4, 0) & 1);

    // R8: blanking
    tag = "R8"; blank_n = 1'b0; tick();
    check("R8 blank forces V5", int'(lvl[2*152 +: 2]), 3);
    blank_n = 1'b1; tick();
    check("R8 line cleared after blank", int'(lvl[2*152 +: 2]), 1);
    pulse_lp();
    col_chk("R8 data kept after blank", 152, pat(4, 0) & 1);

    // R5: cascade pulse returns high after next strobe
    tag = "R5"; ac = 1'b0; pulse_lp(); ein = 1'b0;
    for (int n = 0; n < 20; n++) shift(pat(5, n));
    ein = 1'b1;
    check("R5 enable out low after last group", int'(en1_out), 0);
    shift(8'h3C);
    check("R5 enable out high after next strobe", int'(en1_out), 1);
    pulse_lp();

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule